// File: doc/BRIEF.md
# PC-Relative Signed Halfword Load Unit

This unit carries out one PC-relative "load signed halfword" instruction. The instruction word arrives in one of two 32-bit layouts: format A, with an 8-bit offset split into two nibbles, and format B, with a contiguous 12-bit offset. A format select input picks the layout. The unit also receives the instruction address, a condition-pass flag from the issue stage and a start strobe.

On start the unit decodes the word, checks the fixed fields and classifies the encoding. A valid encoding goes on to address generation. The effective address comes from the instruction address plus the format's pipeline offset, rounded down to a word boundary, with the zero-extended offset then added or subtracted. The unit issues one halfword read on a valid/ready request port and waits for the read data. It then sign-extends the data to a full word and presents it on a one-cycle register write port, together with a done strobe.

Encodings that belong to a neighbouring instruction, and encodings that this unit treats as undefined, retire at once with a flag and make no memory access. An instruction whose condition failed also retires at once, with no access and no flag.

Top module: `pcrel_shload`

## Requirements
- R1: The effective address is based on the instruction address plus 8 (format A, fmt_b_i=0) or plus 4 (format B, fmt_b_i=1), with the two least significant bits then cleared.
- R2: With instruction bit 23 set, the offset is added to the aligned base. With bit 23 clear, it is subtracted. Address arithmetic wraps modulo 2^32.
- R3: In format A the 8-bit offset is instr[11:8]:instr[3:0], zero-extended, and the destination index is instr[15:12].
- R4: In format B the offset is instr[11:0], zero-extended, and the destination index is instr[15:12].
- R5: The 16-bit read data is sign-extended to 32 bits (bit 15 copied into bits 31:16) before it is written.
- R6: A fully valid format A word with bit 24 = 0 and bit 21 = 1 raises other_o together with done_o, one cycle after start, and makes no memory request.
- R7: Format A raises undef_o with done_o, one cycle after start, and makes no request when any of these holds: instr[31:28]=1111; instr[27:25]≠000; bit 22 or bit 20 is 0; instr[19:16]≠1111; instr[7:4]≠1111; the word asks for writeback (bit 24 = 1 with bit 21 = 1, or bit 24 = 0 with bit 21 = 0); or the destination is 1111. A fixed-field mismatch has priority over the R6 case.
- R8: Format B requires instr[31:25]=1111100, bit 24 = 1, instr[22:21]=01, bit 20 = 1 and instr[19:16]=1111. Otherwise it raises undef_o. A matching word with destination 1111 raises other_o. In both cases done_o pulses one cycle after start and no request is made.
- R9: When cond_ok_i is low at start, done_o pulses one cycle later with both flags low, and there is no request and no write.
- R10: For a valid instruction mem_req_o rises the cycle after start. It holds mem_addr_o stable until a cycle with mem_gnt_i high, and drops after that cycle. mem_rvalid_i is ignored before the grant.
- R11: After a grant, the first cycle with mem_rvalid_i high causes wr_en_o and done_o to be high together for exactly the next cycle, with wr_idx_o and wr_data_o valid in that cycle.
- R12: busy_o is high from the cycle after an accepted start until done_o. A start seen while busy is ignored.
- R13: While rst is held, and in the cycle after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin executing instr_i |
| fmt_b_i | input | 1 | 0 = format A, 1 = format B |
| instr_i | input | 32 | Instruction word |
| iaddr_i | input | 32 | Address of the instruction |
| cond_ok_i | input | 1 | Condition passed for this instruction |
| mem_req_o | output | 1 | Halfword read request valid |
| mem_addr_o | output | 32 | Byte address of the read |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 16 | Read data |
| wr_en_o | output | 1 | Destination register write strobe |
| wr_idx_o | output | 4 | Destination register index |
| wr_data_o | output | 32 | Sign-extended load value |
| done_o | output | 1 | Instruction retired |
| other_o | output | 1 | Encoding belongs to another instruction |
| undef_o | output | 1 | Encoding treated as undefined |
| busy_o | output | 1 | Instruction in flight |

## Verification
The bench targets these corner cases:
- A PC that is not word aligned, in both formats. A design that skips the alignment or applies the wrong pipeline offset puts the wrong address on the request.
- A subtraction that wraps below zero. A design that computes the address in a narrower width or with a sign error gets this wrong.
- Read data with bit 15 both set and clear. A design that zero-extends, or replicates the wrong bit, writes the wrong value.
- Each rejection case, including the neighbouring-instruction pattern in each format and a condition failure on a valid word. A design that mis-prioritises these raises the wrong flag or issues a stray read.
- A second start and an early read-valid pulse while a request waits for its grant. A design that accepts either corrupts the address or writes early.

// File: rtl/pcrel_shload_pkg.sv
`timescale 1ns/1ps
package pcrel_shload_pkg;

  typedef enum logic [1:0] {
    CLS_OK    = 2'd0,
    CLS_OTHER = 2'd1,
    CLS_UNDEF = 2'd2
  } cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

  localparam int IMM_W = 12;
  localparam int IDX_W = 4;

  typedef struct packed {
    cls_e              cls;
    logic              up;
    logic [IDX_W-1:0]  rt;
    logic [IMM_W-1:0]  imm;
  } dec_t;

endpackage

// File: rtl/pcrel_shload_decode.sv
`timescale 1ns/1ps
module pcrel_shload_decode
  import pcrel_shload_pkg::*;
(
  input  logic        fmt_b_i,
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  // fixed-field masks and expected values per layout
  localparam logic [31:0] FA_MASK  = 32'h0E5F_00F0;
  localparam logic [31:0] FA_MATCH = 32'h005F_00F0;
  localparam logic [31:0] FB_MASK  = 32'hFF7F_0000;
  localparam logic [31:0] FB_MATCH = 32'hF93F_0000;

  logic fix_a_ok, fix_b_ok, pre_bit, wb_bit, rt_all_ones;

  assign fix_a_ok    = ((instr_i & FA_MASK) == FA_MATCH) && (instr_i[31:28] != 4'hF);
  assign fix_b_ok    = ((instr_i & FB_MASK) == FB_MATCH);
  assign pre_bit     = instr_i[24];
  assign wb_bit      = instr_i[21];
  assign rt_all_ones = (instr_i[15:12] == 4'hF);

  always_comb begin
    dec_o     = '0;
    dec_o.up  = instr_i[23];
    dec_o.rt  = instr_i[15:12];
    dec_o.cls = CLS_OK;
    if (!fmt_b_i) begin
      dec_o.imm = {4'h0, instr_i[11:8], instr_i[3:0]};
      if (!fix_a_ok)                          dec_o.cls = CLS_UNDEF;
      else if (!pre_bit && wb_bit)            dec_o.cls = CLS_OTHER;
      else if (!pre_bit || wb_bit || rt_all_ones) dec_o.cls = CLS_UNDEF;
    end else begin
      dec_o.imm = instr_i[11:0];
      if (!fix_b_ok)        dec_o.cls = CLS_UNDEF;
      else if (rt_all_ones) dec_o.cls = CLS_OTHER;
    end
  end
endmodule

// File: rtl/pcrel_shload_agen.sv
`timescale 1ns/1ps
module pcrel_shload_agen #(
  parameter int XLEN       = 32,
  parameter int IMM_W      = 12,
  parameter int PC_OFS_A   = 8,
  parameter int PC_OFS_B   = 4,
  parameter int ALIGN_BITS = 2
) (
  input  logic             fmt_b_i,
  input  logic [XLEN-1:0]  iaddr_i,
  input  logic             up_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  addr_o
);
  localparam logic [XLEN-1:0] LOW_ONES   = XLEN'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~LOW_ONES;

  logic [XLEN-1:0] pc_val, base, ext_imm;

  assign pc_val  = iaddr_i + (fmt_b_i ? XLEN'(PC_OFS_B) : XLEN'(PC_OFS_A));
  assign base    = pc_val & ALIGN_MASK;
  assign ext_imm = XLEN'(imm_i);
  assign addr_o  = up_i ? (base + ext_imm) : (base - ext_imm);
endmodule

// File: rtl/pcrel_shload_seq.sv
`timescale 1ns/1ps
module pcrel_shload_seq
  import pcrel_shload_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DATA_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cond_ok_i,
  input  cls_e              cls_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [RIDX_W-1:0] rt_i,
  output logic              mem_req_o,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wr_en_o,
  output logic [RIDX_W-1:0] wr_idx_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              done_o,
  output logic              other_o,
  output logic              undef_o,
  output logic              busy_o
);
  localparam int EXT_W = XLEN - DATA_W;

  st_e               st;
  logic              req_q, wr_q, done_q, oth_q, und_q;
  logic [XLEN-1:0]   addr_q, data_q;
  logic [RIDX_W-1:0] idx_q;
  logic [XLEN-1:0]   sext;

  assign sext = {{EXT_W{mem_rdata_i[DATA_W-1]}}, mem_rdata_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      req_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      oth_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      oth_q  <= 1'b0;
      und_q  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            if (!cond_ok_i) begin
              done_q <= 1'b1;
            end else if (cls_i == CLS_OTHER) begin
              done_q <= 1'b1;
              oth_q  <= 1'b1;
            end else if (cls_i == CLS_UNDEF) begin
              done_q <= 1'b1;
              und_q  <= 1'b1;
            end else begin
              st     <= ST_REQ;
              req_q  <= 1'b1;
              addr_q <= addr_i;
              idx_q  <= rt_i;
            end
          end
        end
        ST_REQ: begin
          if (mem_gnt_i) begin
            st    <= ST_WAIT;
            req_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (mem_rvalid_i) begin
            st     <= ST_IDLE;
            wr_q   <= 1'b1;
            done_q <= 1'b1;
            data_q <= sext;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = addr_q;
  assign wr_en_o    = wr_q;
  assign wr_idx_o   = idx_q;
  assign wr_data_o  = data_q;
  assign done_o     = done_q;
  assign other_o    = oth_q;
  assign undef_o    = und_q;
  assign busy_o     = (st != ST_IDLE);
endmodule

// File: rtl/pcrel_shload.sv
`timescale 1ns/1ps
module pcrel_shload
  import pcrel_shload_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int DATA_W   = 16,
  parameter int PC_OFS_A = 8,
  parameter int PC_OFS_B = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              fmt_b_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   iaddr_i,
  input  logic              cond_ok_i,
  output logic              mem_req_o,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [XLEN-1:0]   wr_data_o,
  output logic              done_o,
  output logic              other_o,
  output logic              undef_o,
  output logic              busy_o
);
  dec_t            dec;
  logic [XLEN-1:0] eff_addr;

  pcrel_shload_decode u_dec (
    .fmt_b_i (fmt_b_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  pcrel_shload_agen #(
    .XLEN       (XLEN),
    .IMM_W      (IMM_W),
    .PC_OFS_A   (PC_OFS_A),
    .PC_OFS_B   (PC_OFS_B),
    .ALIGN_BITS (2)
  ) u_agen (
    .fmt_b_i (fmt_b_i),
    .iaddr_i (iaddr_i),
    .up_i    (dec.up),
    .imm_i   (dec.imm),
    .addr_o  (eff_addr)
  );

  pcrel_shload_seq #(
    .XLEN   (XLEN),
    .DATA_W (DATA_W),
    .RIDX_W (IDX_W)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cond_ok_i    (cond_ok_i),
    .cls_i        (dec.cls),
    .addr_i       (eff_addr),
    .rt_i         (dec.rt),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .wr_data_o    (wr_data_o),
    .done_o       (done_o),
    .other_o      (other_o),
    .undef_o      (undef_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/pcrel_shload_chk.sv
`timescale 1ns/1ps
module pcrel_shload_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            start_i,
  input logic            mem_req_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            wr_en_o,
  input logic [XLEN-1:0] wr_data_o,
  input logic            done_o,
  input logic            other_o,
  input logic            undef_o,
  input logic            busy_o
);
  p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_gnt_i) |=> !mem_req_o);

  p_req_from_start_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req_o) |-> $past(start_i));

  p_wr_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> done_o);

  p_wr_single_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |=> !wr_en_o);

  p_sext_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_data_o[XLEN-1:16] == {(XLEN-16){wr_data_o[15]}}));

  p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_en_o, other_o, undef_o}) <= 1);

  p_flag_done_r6: assert property (@(posedge clk) disable iff (rst)
    (other_o || undef_o) |-> (done_o && !mem_req_o));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && !mem_req_o));
endmodule

bind pcrel_shload pcrel_shload_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_gnt_i  (mem_gnt_i),
  .wr_en_o    (wr_en_o),
  .wr_data_o  (wr_data_o),
  .done_o     (done_o),
  .other_o    (other_o),
  .undef_o    (undef_o),
  .busy_o     (busy_o)
);

// File: tb/pcrel_shload_tb_top.sv
`timescale 1ns/1ps
module pcrel_shload_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, fmt_b_i = 1'b0, cond_ok_i = 1'b1;
  logic [31:0] instr_i = '0, iaddr_i = '0;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_req_o, wr_en_o, done_o, other_o, undef_o, busy_o;
  logic [31:0] mem_addr_o, wr_data_o;
  logic [3:0]  wr_idx_o;

  always #2.5 clk = ~clk;

  pcrel_shload dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .fmt_b_i(fmt_b_i),
    .instr_i(instr_i), .iaddr_i(iaddr_i), .cond_ok_i(cond_ok_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .other_o(other_o), .undef_o(undef_o), .busy_o(busy_o)
  );

  int    n_chk = 0, n_fail = 0;
  bit    cmp_en = 1'b0, finished = 1'b0;
  string scen = "R13 reset";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s | %s: actual=%h expected=%h", scen, tag, act, exp);
    end
  endtask

  // encoders built field by field
  function automatic logic [31:0] enc_a(input logic [3:0] cnd, input bit p, input bit u,
                                        input bit w, input logic [3:0] rt, input logic [7:0] imm);
    return {cnd, 3'b000, p, u, 1'b1, w, 1'b1, 4'hF, rt, imm[7:4], 4'hF, imm[3:0]};
  endfunction

  function automatic logic [31:0] enc_b(input bit u, input logic [3:0] rt, input logic [11:0] imm);
    return {7'b1111100, 1'b1, u, 2'b01, 1'b1, 4'hF, rt, imm};
  endfunction

  // 0 = proceed, 1 = other instruction, 2 = undefined
  function automatic int ref_class(input bit fb, input logic [31:0] w);
    bit ok;
    if (!fb) begin
      ok = (w[31:28] != 4'hF) && (w[27:25] == 3'b000) && w[22] && w[20] &&
           (w[19:16] == 4'hF) && (w[7:4] == 4'hF);
      if (!ok) return 2;
      if (w[24] == 1'b0 && w[21] == 1'b1) return 1;
      if (w[24] == 1'b0 || w[21] == 1'b1 || w[15:12] == 4'hF) return 2;
      return 0;
    end
    ok = (w[31:25] == 7'b1111100) && w[24] && (w[22:21] == 2'b01) && w[20] && (w[19:16] == 4'hF);
    if (!ok) return 2;
    if (w[15:12] == 4'hF) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] ref_addr(input bit fb, input logic [31:0] w, input logic [31:0] ia);
    longint pcv, basev, off, a;
    pcv   = longint'(ia) + (fb ? 4 : 8);
    basev = (pcv / 4) * 4;
    off   = fb ? longint'(w[11:0]) : longint'({w[11:8], w[3:0]});
    a     = w[23] ? basev + off : basev - off;
    return a[31:0];
  endfunction

  // behavioural reference
  int          m_phase = 0;
  bit          e_req = 0, e_wr = 0, e_done = 0, e_oth = 0, e_und = 0;
  logic [31:0] e_addr = '0, e_data = '0;
  logic [3:0]  e_idx = '0;

  always @(posedge clk) begin
    int c;
    e_wr = 0; e_done = 0; e_oth = 0; e_und = 0;
    if (rst) begin
      m_phase = 0; e_req = 0;
    end else if (m_phase == 0) begin
      if (start_i) begin
        c = ref_class(fmt_b_i, instr_i);
        if (!cond_ok_i) e_done = 1;
        else if (c == 1) begin e_done = 1; e_oth = 1; end
        else if (c == 2) begin e_done = 1; e_und = 1; end
        else begin
          m_phase = 1; e_req = 1;
          e_addr  = ref_addr(fmt_b_i, instr_i, iaddr_i);
          e_idx   = instr_i[15:12];
        end
      end
    end else if (m_phase == 1) begin
      if (mem_gnt_i) begin m_phase = 2; e_req = 0; end
    end else begin
      if (mem_rvalid_i) begin
        m_phase = 0; e_wr = 1; e_done = 1;
        e_data = {{16{mem_rdata_i[15]}}, mem_rdata_i};
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(mem_req_o === e_req, "R10 request", 32'(mem_req_o), 32'(e_req));
      if (e_req) chk(mem_addr_o === e_addr, "R1 R2 R3 R4 address", mem_addr_o, e_addr);
      chk(wr_en_o === e_wr, "R11 write strobe", 32'(wr_en_o), 32'(e_wr));
      if (e_wr) begin
        chk(wr_data_o === e_data, "R5 write data", wr_data_o, e_data);
        chk(wr_idx_o === e_idx, "R3 R4 write index", 32'(wr_idx_o), 32'(e_idx));
      end
      chk(done_o === e_done, "R11 done", 32'(done_o), 32'(e_done));
      chk(other_o === e_oth, "R6 R8 other flag", 32'(other_o), 32'(e_oth));
      chk(undef_o === e_und, "R7 R8 undef flag", 32'(undef_o), 32'(e_und));
      chk(busy_o === (m_phase != 0), "R12 busy", 32'(busy_o), 32'(m_phase != 0));
    end
  end

  task automatic run(input string nm, input bit fb, input logic [31:0] w, input logic [31:0] ia,
                     input bit cok, input int gdly, input int rdly, input logic [15:0] rd,
                     input bit poke);
    bit acc;
    scen = nm;
    acc = cok && (ref_class(fb, w) == 0);
    @(negedge clk);
    start_i = 1; fmt_b_i = fb; instr_i = w; iaddr_i = ia; cond_ok_i = cok;
    @(negedge clk);
    start_i = 0;
    if (acc) begin
      for (int i = 0; i < gdly; i++) begin
        if (poke && i == 0) begin
          start_i = 1; instr_i = enc_b(1'b1, 4'h3, 12'h444); fmt_b_i = 1;
          mem_rvalid_i = 1; mem_rdata_i = 16'hDEAD;
        end else begin
          start_i = 0; mem_rvalid_i = 0;
        end
        @(negedge clk);
      end
      start_i = 0; mem_rvalid_i = 0;
      mem_gnt_i = 1;
      @(negedge clk);
      mem_gnt_i = 0;
      for (int i = 0; i < rdly; i++) @(negedge clk);
      mem_rvalid_i = 1; mem_rdata_i = rd;
      @(negedge clk);
      mem_rvalid_i = 0; mem_rdata_i = 16'h0;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(!mem_req_o && !wr_en_o && !done_o && !other_o && !undef_o && !busy_o,
        "R13 outputs during reset", {26'd0, mem_req_o, wr_en_o, done_o, other_o, undef_o, busy_o}, 32'd0);
    cmp_en = 1;
    rst = 0;
    @(negedge clk);
    chk(!mem_req_o && !wr_en_o && !done_o && !busy_o, "R13 outputs after release",
        {28'd0, mem_req_o, wr_en_o, done_o, busy_o}, 32'd0);

    run("R1 R3 R5 A add unaligned", 0, enc_a(4'hE, 1, 1, 0, 4'h2, 8'h5A), 32'h1002, 1, 2, 3, 16'h8001, 0);
    run("R2 R3 R5 A sub wrap",      0, enc_a(4'h0, 1, 0, 0, 4'h7, 8'hFF), 32'h0000, 1, 0, 0, 16'h7FFF, 0);
    run("R1 R4 R5 B add max",       1, enc_b(1, 4'hD, 12'hFFF), 32'h2003, 1, 0, 1, 16'h0080, 0);
    run("R2 R4 B sub",              1, enc_b(0, 4'h0, 12'h010), 32'h0100, 1, 1, 0, 16'hFF00, 0);
    run("R10 R12 poke while busy",  0, enc_a(4'h1, 1, 1, 0, 4'h9, 8'h00), 32'h3FFE, 1, 3, 2, 16'h1234, 1);
    run("R6 A other",               0, enc_a(4'hE, 0, 1, 1, 4'h1, 8'h10), 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A writeback pre",       0, enc_a(4'hE, 1, 1, 1, 4'h1, 8'h10), 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A writeback post",      0, enc_a(4'hE, 0, 0, 0, 4'h1, 8'h10), 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A dest 15",             0, enc_a(4'hE, 1, 1, 0, 4'hF, 8'h10), 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A cond 1111",           0, enc_a(4'hF, 1, 1, 0, 4'h1, 8'h10), 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A bits7:4 wrong",       0, enc_a(4'hE, 1, 1, 0, 4'h1, 8'h10) & 32'hFFFF_FF7F, 32'h40, 1, 0, 0, 16'h0, 0);
    run("R7 A fixed beats other",   0, enc_a(4'hE, 0, 1, 1, 4'h1, 8'h10) & 32'hFFF0_FFFF, 32'h40, 1, 0, 0, 16'h0, 0);
    run("R8 B dest 15 other",       1, enc_b(1, 4'hF, 12'h123), 32'h80, 1, 0, 0, 16'h0, 0);
    run("R8 B size field wrong",    1, enc_b(1, 4'h2, 12'h123) ^ 32'h0060_0000, 32'h80, 1, 0, 0, 16'h0, 0);
    run("R9 cond fail valid A",     0, enc_a(4'hE, 1, 1, 0, 4'h4, 8'h20), 32'h80, 0, 0, 0, 16'h0, 0);
    run("R9 cond fail other B",     1, enc_b(1, 4'hF, 12'h1), 32'h80, 0, 0, 0, 16'h0, 0);
    run("R5 R11 back to back",      1, enc_b(1, 4'h6, 12'h002), 32'hFFFF_FFFC, 1, 0, 0, 16'h8000, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule